// File: doc/BRIEF.md
# Mirrored-Bank Register File with Two Read Ports

This block is a processor register file with 32 registers of 32 bits. It offers two combinational read ports and one write port that commits on the rising clock edge. A datapath uses it to fetch both source operands of an instruction in the same cycle and to retire one result per cycle.

The two read ports do not share one multi-ported array. The block keeps two complete copies of the register set, each with a single read path. Every write is applied to both copies with the same address and data on the same edge. Port A always reads copy 0 and port B always reads copy 1. The copies are therefore always equal, and the two ports can address different registers at the same time.

Register 0 is hard-wired to zero. A synchronous active-low reset clears every register in both copies.

Top module: `rf_dual_bank`

## Requirements
- R1: `rd_data_a` shows the register selected by `rd_addr_a`, and `rd_data_b` shows the register selected by `rd_addr_b`. Both are combinational in the same cycle, and the two addresses are independent. When both addresses are equal, both ports show the same value.
- R2: When `rst_n` is 0 at a rising edge, every register in both copies becomes 0.
- R3: When `wr_en` is 1 and `wr_addr` is not 0 at a rising edge, `wr_data` is stored into that register in both copies. From the following cycle it is visible on both read ports.
- R4: The two copies hold identical contents at every rising edge after reset.
- R5: Address 0 always reads as 0 on both ports. A write with `wr_addr` = 0 changes no register.
- R6: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` carry.
- R7: During a cycle in which a register is being written, a read of that register returns its old value until the edge. No bypass path exists.
- R8: Reset has priority over a write. A write requested in a reset cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this edge |
| wr_addr | input | 5 | Register written |
| wr_data | input | 32 | Value written |
| rd_addr_a | input | 5 | Register read on port A (copy 0) |
| rd_data_a | output | 32 | Port A read value |
| rd_addr_b | input | 5 | Register read on port B (copy 1) |
| rd_data_b | output | 32 | Port B read value |

## Verification
The assertions take for granted that reset is held low for at least one rising edge before any write. They also assume that all inputs are known, not X, at every sampled edge. Only under those conditions do the two copies start equal and stay equal.

The stimulus starts with `rst_n` low from time zero. It drives every input to a defined value on the falling edge. It reaches a reset-during-write case only after both copies have been written with matching data, so the mirror check stays meaningful across that event.

// File: rtl/rf_pkg.sv
// Package: shared sizing constants for the mirrored-bank register file.
// Assumes the register count is a power of two so addresses are dense.
package rf_pkg;
    localparam int RF_DATA_W   = 32;
    localparam int RF_NUM_REGS = 32;
    localparam int RF_BANKS    = 2;
endpackage

// File: rtl/rf_wr_gate.sv
// Module: rf_wr_gate
// Turns the write request into one enable per register row. The enable for
// row 0 is held low, so the zero register is never written. A reset cycle
// suppresses every enable, which gives reset priority over a write.
// Assumes wr_addr is known whenever wr_en is high.
module rf_wr_gate #(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [NUM_REGS-1:0] row_we
);
    logic live;

    // Purpose: a write is live only outside reset.
    always_comb begin
        live = rst_n & wr_en;
    end

    genvar r;
    generate
        for (r = 0; r < NUM_REGS; r++) begin : g_row
            if (r == 0) begin : g_zero
                assign row_we[r] = 1'b0;
            end else begin : g_dec
                assign row_we[r] = live && (wr_addr == ADDR_W'(r));
            end
        end
    endgenerate
endmodule

// File: rtl/rf_rd_mux.sv
// Module: rf_rd_mux
// Combinational read selector for one bank. Address 0 is forced to zero,
// independent of what row 0 holds.
// Assumes rows is a packed image with row r in bits [r*DATA_W +: DATA_W].
module rf_rd_mux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data
);
    // Purpose: pick one row, hard zero for register 0.
    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else begin
            rd_data = rows[rd_addr];
        end
    end
endmodule

// File: rtl/rf_bank.sv
// Module: rf_bank
// One full copy of the register set with a single read path. Rows update on
// the rising edge from per-row enables; synchronous active-low reset clears
// all rows. The whole image is exported for mirror checking.
// Assumes at most one bit of row_we is set per cycle.
module rf_bank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_REGS-1:0]          row_we,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_REGS*DATA_W-1:0]   img
);
    logic [NUM_REGS-1:0][DATA_W-1:0] rows;

    // Purpose: clear on reset, otherwise load enabled rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (row_we[r]) begin
                    rows[r] <= wr_data;
                end
            end
        end
    end

    // Purpose: flatten the contents for the checker.
    always_comb begin
        img = rows;
    end

    rf_rd_mux #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) rd_mux_i (
        .rows    (rows),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/rf_dual_bank.sv
// Module: rf_dual_bank
// Two-read, one-write register file built from mirrored single-read banks.
// One shared row-enable vector feeds every bank, so each write lands in all
// copies on the same edge. Read port A is served by bank 0 and port B by bank 1.
// Assumes reset is applied before the first write.
module rf_dual_bank #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]   wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_a,
    output logic [DATA_W-1:0]             rd_data_a,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_b,
    output logic [DATA_W-1:0]             rd_data_b
);
    localparam int ADDR_W = $clog2(NUM_REGS);
    localparam int NBANK  = rf_pkg::RF_BANKS;
    localparam int IMG_W  = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] row_we;
    logic [ADDR_W-1:0]   bank_rd_addr [NBANK];
    logic [DATA_W-1:0]   bank_rd_data [NBANK];
    logic [IMG_W-1:0]    bank_img     [NBANK];
    logic [IMG_W-1:0]    img_bank0;
    logic [IMG_W-1:0]    img_bank1;

    // Purpose: route each read port to its own bank.
    always_comb begin
        bank_rd_addr[0] = rd_addr_a;
        bank_rd_addr[1] = rd_addr_b;
        rd_data_a       = bank_rd_data[0];
        rd_data_b       = bank_rd_data[1];
        img_bank0       = bank_img[0];
        img_bank1       = bank_img[1];
    end

    rf_wr_gate #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) wr_gate_i (
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .row_we  (row_we)
    );

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            rf_bank #(
                .DATA_W   (DATA_W),
                .NUM_REGS (NUM_REGS),
                .ADDR_W   (ADDR_W)
            ) bank_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .row_we  (row_we),
                .wr_data (wr_data),
                .rd_addr (bank_rd_addr[b]),
                .rd_data (bank_rd_data[b]),
                .img     (bank_img[b])
            );
        end
    endgenerate
endmodule

// File: rtl/rf_dual_bank_chk.sv
// Module: rf_dual_bank_chk
// Checker bound to rf_dual_bank. It compares the two bank images with each
// other and relates the read ports to earlier writes.
// Assumes inputs are known at every sampled edge and reset comes first.
module rf_dual_bank_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [ADDR_W-1:0]           rd_addr_a,
    input logic [DATA_W-1:0]           rd_data_a,
    input logic [ADDR_W-1:0]           rd_addr_b,
    input logic [DATA_W-1:0]           rd_data_b,
    input logic [NUM_REGS*DATA_W-1:0]  img0,
    input logic [NUM_REGS*DATA_W-1:0]  img1
);
    a_r1_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    a_r2_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (img0 == '0 && img1 == '0));

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=>
            ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))));

    a_r4_banks_match: assert property (@(posedge clk) disable iff (!rst_n)
        img0 == img1);

    a_r5_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(img0));

    a_r8_reset_beats_write: assert property (@(posedge clk)
        (!rst_n && wr_en) |=> (img1 == '0));
endmodule

bind rf_dual_bank rf_dual_bank_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .img0      (img_bank0),
    .img1      (img_bank1)
);

// File: tb/rf_dual_bank_tb_top.sv
module rf_dual_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    int checks = 0;
    int failures = 0;
    logic [31:0] ref_q [32];

    always #10 clk = ~clk;

    rf_dual_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b));

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    // Each vector gives the reads expected before its own edge.
    localparam vec_t VECS [8] = '{
        '{1'b1, 5'd3,  32'h1111_0003, 5'd3,  5'd0,  32'h0,         32'h0},
        '{1'b1, 5'd7,  32'hA5A5_0007, 5'd3,  5'd7,  32'h1111_0003, 32'h0},
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd7,  5'd0,  32'hA5A5_0007, 32'h0},
        '{1'b0, 5'd3,  32'hDEAD_BEEF, 5'd0,  5'd3,  32'h0,         32'h1111_0003},
        '{1'b1, 5'd31, 32'h8000_0001, 5'd3,  5'd31, 32'h1111_0003, 32'h0},
        '{1'b1, 5'd3,  32'h0000_0033, 5'd31, 5'd3,  32'h8000_0001, 32'h1111_0003},
        '{1'b0, 5'd0,  32'h0,         5'd3,  5'd3,  32'h0000_0033, 32'h0000_0033},
        '{1'b0, 5'd0,  32'h0,         5'd31, 5'd7,  32'h8000_0001, 32'hA5A5_0007}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, read before the rising edge, then commit.
    task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
        #2;
    endtask

    task automatic commit(input logic we, input logic [4:0] wa, input logic [31:0] wd);
        @(posedge clk);
        if (rst_n && we && wa != 5'd0) ref_q[wa] = wd;
    endtask

    task automatic sweep_all(input string req);
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            chk(req, rd_data_a, ref_q[i]);
            chk(req, rd_data_b, ref_q[31 - i]);
            commit(1'b0, 5'd0, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_q[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all registers read zero after reset
        sweep_all("R2 reset state");

        // Table walk: R1 R3 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            drive(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].ra, VECS[v].rb);
            chk("R1/R3/R5/R6/R7 port A table", rd_data_a, VECS[v].ea);
            chk("R1/R3/R5/R6/R7 port B table", rd_data_b, VECS[v].eb);
            commit(VECS[v].we, VECS[v].wa, VECS[v].wd);
        end

        // Random sequence against the reference array: R1 R3 R4 R7
        for (int n = 0; n < 400; n++) begin
            logic        we;
            logic [4:0]  wa, ra, rb;
            logic [31:0] wd;
            we = ($urandom_range(0, 3) != 0);
            wa = 5'($urandom_range(0, 31));
            wd = $urandom;
            ra = ($urandom_range(0, 3) == 0) ? wa : 5'($urandom_range(0, 31));
            rb = ($urandom_range(0, 3) == 0) ? ra : 5'($urandom_range(0, 31));
            drive(we, wa, wd, ra, rb);
            chk("R1 R7 random port A", rd_data_a, ref_q[ra]);
            chk("R4 random port B from mirror", rd_data_b, ref_q[rb]);
            commit(we, wa, wd);
        end

        // R4: every register equal on both ports after random writes
        sweep_all("R4 mirror sweep");

        // R6: disabled writes to every address leave all values
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'(i), 32'hCAFE_F00D, 5'd1, 5'd2);
            commit(1'b0, 5'(i), 32'hCAFE_F00D);
        end
        sweep_all("R6 idle sweep");

        // R5: write to address 0 ignored, both ports read zero there
        drive(1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd0);
        commit(1'b1, 5'd0, 32'h1234_5678);
        drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
        chk("R5 zero reg port A", rd_data_a, 32'h0);
        chk("R5 zero reg port B", rd_data_b, 32'h0);
        commit(1'b0, 5'd0, 32'h0);

        // R3: back-to-back writes to the same register, last one wins
        drive(1'b1, 5'd9, 32'h0000_0A0A, 5'd9, 5'd9);
        commit(1'b1, 5'd9, 32'h0000_0A0A);
        drive(1'b1, 5'd9, 32'h0000_0B0B, 5'd9, 5'd9);
        chk("R7 old value port A", rd_data_a, 32'h0000_0A0A);
        commit(1'b1, 5'd9, 32'h0000_0B0B);
        drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd9);
        chk("R3 last write port A", rd_data_a, 32'h0000_0B0B);
        chk("R3 last write port B", rd_data_b, 32'h0000_0B0B);
        commit(1'b0, 5'd0, 32'h0);

        // R8: reset with a write pending clears everything
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h5555_5555;
        @(posedge clk);
        for (int i = 0; i < 32; i++) ref_q[i] = 32'h0;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
        drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd5);
        chk("R8 reset beats write port A", rd_data_a, 32'h0);
        chk("R8 reset beats write port B", rd_data_b, 32'h0);
        commit(1'b0, 5'd0, 32'h0);
        sweep_all("R2 R8 post-reset sweep");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule